// File: doc/BRIEF.md
# Bounce-Tolerant Ordered-Switch Lock

This block is a clocked state machine that watches a bank of slide switches. It unlocks only when the switches start from all off and are then raised one at a time, from the most significant switch downward. With the default eight switches and four steps, the accepted sequence is 00000000, 10000000, 11000000, 11100000 and 11110000. When the last pattern arrives, every LED lights. The LEDs stay lit until all switches are back off.

The switch lines are asynchronous, so they pass through a two-stage synchronizer before the state machine sees them. Contact bounce is handled inside the state graph itself and needs no timer. While the lock is at a step, a brief drop back to the previous step's pattern is treated like holding the current pattern. Any other pattern sends the lock to an error state. It leaves that state only when it sees all switches off. When the lock is not open, the state code is shown on the low LEDs so the lock can be watched while it is used.

Top module: `seqlock_top`

## Requirements
- R1: A synchronous reset puts the machine in the error state (code 0) and drives all LEDs to 0.
- R2: In the error state (code 0), the all-off pattern moves the lock to the start state (code 1). Every other pattern keeps it in error.
- R3: In the start state (code 1), all-off holds start, 10000000 moves to the first step (code 2), and any other pattern moves to error.
- R4: At step codes 2, 3 and 4 (1, 2 or 3 top switches raised), the step's own pattern holds the code. The pattern with one more top switch raised advances the code by one.
- R5: At step codes 2 to 4, the pattern of the preceding position (one fewer top switch raised) holds the code without error.
- R6: At step codes 2 to 4, any pattern not covered by R4, R5 or R7 moves the lock to error.
- R7: At code 4, the pattern 11110000 moves the lock to the open state (code 5), and all eight LEDs are driven high.
- R8: In the open state, any non-zero pattern keeps the lock open. The all-off pattern moves it to start (code 1).
- R9: When the lock is not open, LED bits 3..0 show the state code and bits 7..4 are 0. The state output always carries the code.
- R10: A switch change reaches the state on the third rising clock edge after it is applied, through two synchronizer stages, and not earlier.
- R11: The state code never leaves the range 0 to 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; all state changes on the rising edge |
| rst_i | input | 1 | Synchronous active-high reset |
| sw_i | input | 8 | Asynchronous switch lines, bit 7 is raised first |
| leds_o | output | 8 | All high when open, otherwise the state code on bits 3..0 |
| state_o | output | 4 | Current state code for debugging |

## Verification
The bench walks the lock to every reachable state and applies all 256 switch patterns there, so every transition of the graph is compared with a model built from the requirements. The bounce case is the important one. A design without it fails the bounce sequence by landing in error. A design that accepts too much, such as letting a two-step fallback hold or skipping a step, shows up as a wrong code in the sweep. A latency that is one register short or long is caught by checking that the state is unchanged after the second edge. Directed runs cover a wrong-order entry that must stick in error until all switches are off, recovery after that, and a partial clear while open, which must not relock.

// File: rtl/seqlock_pkg.sv
package seqlock_pkg;

   // per-level decision once the switch pattern has been classified
   typedef enum logic [1:0] {
      ACT_FAIL = 2'd0,
      ACT_HOLD = 2'd1,
      ACT_ADV  = 2'd2
   } lvl_act_t;

   // code of the state in which lvl top switches are raised (0 = start)
   function automatic int unsigned level_code(input int unsigned lvl);
      return lvl + 1;
   endfunction

endpackage

// File: rtl/seqlock_sync.sv
module seqlock_sync #(
   parameter int unsigned            W       = 8,
   parameter int unsigned            STAGES  = 2,
   parameter logic        [W-1:0]    RST_VAL = '1
) (
   input  logic         clk_i,
   input  logic         rst_i,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);

   logic [W-1:0] stg_q [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_head
         always_ff @(posedge clk_i) begin
            if (rst_i) stg_q[s] <= RST_VAL;
            else       stg_q[s] <= d_i;
         end
      end else begin : g_tail
         always_ff @(posedge clk_i) begin
            if (rst_i) stg_q[s] <= RST_VAL;
            else       stg_q[s] <= stg_q[s-1];
         end
      end
   end

   assign q_o = stg_q[STAGES-1];

endmodule

// File: rtl/seqlock_match.sv
module seqlock_match #(
   parameter int unsigned SW_W  = 8,
   parameter int unsigned STEPS = 4
) (
   input  logic [SW_W-1:0] sw_i,
   output logic [STEPS:0]  hit_o
);

   // hit_o[k] is set when exactly the top k switches are raised
   for (genvar k = 0; k <= STEPS; k++) begin : g_lvl
      localparam logic [SW_W-1:0] PAT = ~({SW_W{1'b1}} >> k);
      assign hit_o[k] = (sw_i == PAT);
   end

endmodule

// File: rtl/seqlock_fsm.sv
module seqlock_fsm
   import seqlock_pkg::*;
#(
   parameter int unsigned STEPS   = 4,
   parameter int unsigned STATE_W = 4
) (
   input  logic               clk_i,
   input  logic               rst_i,
   input  logic [STEPS:0]     hit_i,
   output logic [STATE_W-1:0] state_o
);

   localparam logic [STATE_W-1:0] C_ERR   = '0;
   localparam logic [STATE_W-1:0] C_START = STATE_W'(level_code(0));
   localparam logic [STATE_W-1:0] C_OPEN  = STATE_W'(level_code(STEPS));
   localparam logic [STATE_W-1:0] C_ONE   = STATE_W'(1);

   logic [STATE_W-1:0] state_q;
   logic [STATE_W-1:0] state_d;
   lvl_act_t           act [STEPS];

   // decision per level; the first level has no predecessor to fall back to
   for (genvar k = 0; k < STEPS; k++) begin : g_act
      if (k == 0) begin : g_first
         assign act[k] = hit_i[k]   ? ACT_HOLD :
                         hit_i[k+1] ? ACT_ADV  : ACT_FAIL;
      end else begin : g_later
         assign act[k] = (hit_i[k] || hit_i[k-1]) ? ACT_HOLD :
                         hit_i[k+1]                ? ACT_ADV  : ACT_FAIL;
      end
   end

   always_comb begin
      state_d = C_ERR;
      if (state_q == C_ERR) begin
         state_d = hit_i[0] ? C_START : C_ERR;
      end else if (state_q == C_OPEN) begin
         state_d = hit_i[0] ? C_START : C_OPEN;
      end else begin
         for (int k = 0; k < STEPS; k++) begin
            if (state_q == STATE_W'(level_code(k))) begin
               unique case (act[k])
                  ACT_HOLD: state_d = state_q;
                  ACT_ADV:  state_d = state_q + C_ONE;
                  default:  state_d = C_ERR;
               endcase
            end
         end
      end
   end

   always_ff @(posedge clk_i) begin
      if (rst_i) state_q <= C_ERR;
      else       state_q <= state_d;
   end

   assign state_o = state_q;

endmodule

// File: rtl/seqlock_leds.sv
module seqlock_leds #(
   parameter int unsigned SW_W      = 8,
   parameter int unsigned STATE_W   = 4,
   parameter int unsigned OPEN_CODE = 5
) (
   input  logic [STATE_W-1:0] state_i,
   output logic [SW_W-1:0]    leds_o
);

   localparam logic [STATE_W-1:0] C_OPEN = STATE_W'(OPEN_CODE);

   assign leds_o = (state_i == C_OPEN) ? {SW_W{1'b1}} : SW_W'(state_i);

endmodule

// File: rtl/seqlock_top.sv
module seqlock_top #(
   parameter int unsigned SW_W        = 8,
   parameter int unsigned STEPS       = 4,
   parameter int unsigned STATE_W     = 4,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic               clk_i,
   input  logic               rst_i,
   input  logic [SW_W-1:0]    sw_i,
   output logic [SW_W-1:0]    leds_o,
   output logic [STATE_W-1:0] state_o
);

   localparam int unsigned OPEN_CODE = STEPS + 1;

   if (STEPS < 1 || STEPS > SW_W) begin : g_bad_steps
      $error("seqlock_top: STEPS must lie in 1..SW_W");
   end
   if ((64'd1 << STATE_W) <= 64'(OPEN_CODE)) begin : g_bad_state_w
      $error("seqlock_top: STATE_W too narrow for the open code");
   end
   if (STATE_W > SW_W) begin : g_bad_mirror
      $error("seqlock_top: state code must fit on the LED bus");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("seqlock_top: at least two synchronizer stages required");
   end

   logic [SW_W-1:0] sw_s;
   logic [STEPS:0]  hit;
   logic [STATE_W-1:0] state;

   // reset value all ones: non-zero, so the lock cannot slip into start
   seqlock_sync #(
      .W       (SW_W),
      .STAGES  (SYNC_STAGES),
      .RST_VAL ({SW_W{1'b1}})
   ) sync_i (
      .clk_i (clk_i),
      .rst_i (rst_i),
      .d_i   (sw_i),
      .q_o   (sw_s)
   );

   seqlock_match #(
      .SW_W  (SW_W),
      .STEPS (STEPS)
   ) match_i (
      .sw_i  (sw_s),
      .hit_o (hit)
   );

   seqlock_fsm #(
      .STEPS   (STEPS),
      .STATE_W (STATE_W)
   ) fsm_i (
      .clk_i   (clk_i),
      .rst_i   (rst_i),
      .hit_i   (hit),
      .state_o (state)
   );

   seqlock_leds #(
      .SW_W      (SW_W),
      .STATE_W   (STATE_W),
      .OPEN_CODE (OPEN_CODE)
   ) leds_i (
      .state_i (state),
      .leds_o  (leds_o)
   );

   assign state_o = state;

endmodule

// File: rtl/seqlock_chk.sv
module seqlock_chk #(
   parameter int unsigned SW_W    = 8,
   parameter int unsigned STEPS   = 4,
   parameter int unsigned STATE_W = 4
) (
   input logic               clk_i,
   input logic               rst_i,
   input logic [SW_W-1:0]    leds_o,
   input logic [STATE_W-1:0] state_o
);

   localparam logic [STATE_W-1:0] C_ERR   = '0;
   localparam logic [STATE_W-1:0] C_START = STATE_W'(1);
   localparam logic [STATE_W-1:0] C_OPEN  = STATE_W'(STEPS + 1);
   localparam logic [STATE_W-1:0] C_ONE   = STATE_W'(1);

   // R1
   reset_to_err_chk: assert property (@(posedge clk_i)
      rst_i |=> (state_o == C_ERR));

   // R2
   err_exit_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      (state_o == C_ERR) |=> (state_o == C_ERR || state_o == C_START));

   // R4
   no_skip_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      (state_o >= C_START && state_o < C_OPEN) |=>
         (state_o == C_ERR || state_o == $past(state_o) ||
          state_o == $past(state_o) + C_ONE));

   // R8
   open_exit_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      (state_o == C_OPEN) |=> (state_o == C_OPEN || state_o == C_START));

   // R7
   open_leds_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      (state_o == C_OPEN) |-> (leds_o == {SW_W{1'b1}}));

   // R9
   mirror_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      (state_o != C_OPEN) |-> (leds_o == SW_W'(state_o)));

   // R11
   code_range_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      state_o <= C_OPEN);

endmodule

bind seqlock_top seqlock_chk #(
   .SW_W    (SW_W),
   .STEPS   (STEPS),
   .STATE_W (STATE_W)
) chk_i (
   .clk_i   (clk_i),
   .rst_i   (rst_i),
   .leds_o  (leds_o),
   .state_o (state_o)
);

// File: tb/seqlock_tb.sv
module seqlock_top_tb_top;

   localparam time CLK_PERIOD = 10ns;
   localparam int  WATCHDOG   = 150000;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [7:0] sw  = 8'h01;
   logic [7:0] leds;
   logic [3:0] state;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   seqlock_top dut_i (
      .clk_i   (clk),
      .rst_i   (rst),
      .sw_i    (sw),
      .leds_o  (leds),
      .state_o (state)
   );

   function automatic logic [7:0] pat(input int k);
      logic [7:0] m;
      m = 8'hFF << (8 - k);
      return m;
   endfunction

   // expected next code from the requirements
   function automatic logic [3:0] model(input logic [3:0] s, input logic [7:0] v);
      int k;
      if (s == 4'd0) return (v == 8'h00) ? 4'd1 : 4'd0;
      if (s == 4'd5) return (v == 8'h00) ? 4'd1 : 4'd5;
      k = int'(s) - 1;
      if (v == pat(k))             return s;
      if (v == pat(k + 1))         return s + 4'd1;
      if (k >= 1 && v == pat(k-1)) return s;
      return 4'd0;
   endfunction

   function automatic logic [7:0] exp_leds(input logic [3:0] s);
      return (s == 4'd5) ? 8'hFF : {4'h0, s};
   endfunction

   task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual=%02h expected=%02h", tag, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
         $finish;
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1;
      sw  = 8'h01;
      repeat (3) @(negedge clk);
      rst = 1'b0;
   endtask

   // apply a pattern and wait until the state has taken it (R10)
   task automatic step(input logic [7:0] v);
      @(negedge clk);
      sw = v;
      repeat (3) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic go_to(input int s);
      do_reset();
      if (s >= 1) step(8'h00);
      for (int k = 1; k < s; k++) step(pat(k));
   endtask

   function automatic string tag_for(input int s, input logic [7:0] v, input logic [3:0] e);
      if (s == 0) return "R2";
      if (s == 5) return "R8";
      if (e == 4'd5) return "R7";
      if (s == 1) return "R3";
      if (e == 4'd0) return "R6";
      if (v == pat(s - 2)) return "R5";
      return "R4";
   endfunction

   initial begin
      repeat (WATCHDOG) @(posedge clk);
      n_checks++;
      n_fail++;
      $display("FAIL R1 watchdog: actual=timeout expected=completion");
      finish_run();
   end

   initial begin
      // R1: reset state
      @(negedge clk);
      @(negedge clk);
      check("R1 state", {4'h0, state}, 8'h00);
      check("R1 leds", leds, 8'h00);
      do_reset();
      step(8'h40);
      check("R2 stays error", {4'h0, state}, 8'h00);

      // clean sequence
      step(8'h00);
      check("R2 to start", {4'h0, state}, 8'h01);
      step(8'h80);
      check("R3 first step", {4'h0, state}, 8'h02);
      check("R9 leds mirror", leds, 8'h02);
      step(8'hC0);
      step(8'hE0);
      check("R4 third step", {4'h0, state}, 8'h04);
      step(8'hF0);
      check("R7 open", {4'h0, state}, 8'h05);
      check("R7 leds", leds, 8'hFF);
      step(8'h80);
      check("R8 partial clear holds", {4'h0, state}, 8'h05);
      step(8'h00);
      check("R8 all off to start", {4'h0, state}, 8'h01);

      // bouncing sequence: each new switch drops back once, one cycle
      for (int k = 1; k <= 4; k++) begin
         @(negedge clk); sw = pat(k);
         @(negedge clk); sw = pat(k - 1);
         @(negedge clk); sw = pat(k);
         repeat (3) @(negedge clk);
      end
      check("R5 bounce reaches open", {4'h0, state}, 8'h05);
      step(8'h00);

      // wrong order, then recovery through all off
      step(8'h80);
      step(8'hA0);
      check("R6 wrong order", {4'h0, state}, 8'h00);
      step(8'hC0);
      check("R2 no re-entry", {4'h0, state}, 8'h00);
      step(8'h00);
      step(8'h80);
      step(8'hC0);
      step(8'hE0);
      step(8'hF0);
      check("R7 recovered open", leds, 8'hFF);

      // R10: exact latency
      step(8'h00);
      @(negedge clk); sw = 8'h80;
      repeat (2) @(posedge clk);
      @(negedge clk);
      check("R10 not after two edges", {4'h0, state}, 8'h01);
      @(posedge clk);
      @(negedge clk);
      check("R10 after third edge", {4'h0, state}, 8'h02);

      // sweep: every reachable state against every pattern
      for (int s = 0; s <= 5; s++) begin
         for (int v = 0; v < 256; v++) begin
            logic [3:0] e;
            go_to(s);
            e = model(4'(s), 8'(v));
            @(negedge clk); sw = 8'(v);
            repeat (2) @(posedge clk);
            @(negedge clk);
            if (e != 4'(s)) check("R10 early change", {4'h0, state}, 8'(s));
            @(posedge clk);
            @(negedge clk);
            check(tag_for(s, 8'(v), e), {4'h0, state}, {4'h0, e});
            check(e == 4'd5 ? "R7" : "R9", leds, exp_leds(e));
            check("R11 code range", {4'h0, state} <= 8'h05 ? 8'h01 : 8'h00, 8'h01);
         end
      end

      finish_run();
   end

endmodule